// File: doc/BRIEF.md
# Single Precision Result Packer

This unit turns an unpacked floating-point result into a 32-bit IEEE-754 single-precision word. The input is a class code, a sign, an unbiased exponent, and a 26-bit significand. The significand holds the integer bit, 23 fraction bits, and a guard bit and a round bit below them. A separate sticky bit comes with it. The unit adds the exponent bias and denormalizes results that are too small, folding every bit it shifts out into sticky. It then rounds under one of four modes. Finally it encodes zeros, infinities, NaNs, overflowed results and underflowed results.

With each packed word the unit also reports four per-result flags: overflow, underflow, inexact and rounded. It also reports a 5-bit result-class field that describes the result.

The per-result flags and the class field form the replaced part of a status state, and they are rewritten on every accepted result. Three summary bits for overflow, underflow and inexact form the accumulated part: each is only ever ORed with new events. Everything the unit produces is loaded one clock after a valid strobe. The unit has no other storage.

Top module: `sp_result_packer`

## Requirements
- R1: While reset is asserted and after it is released, every output is zero until the first accepted result.
- R2: One clock after `in_valid` is high, `out_valid` is high for one cycle and the outputs show the result for the inputs sampled in that cycle. When `in_valid` is low, all outputs except `out_valid` keep their values whatever the other inputs do. The class field `out_cls` carries bit 4 = class, bit 3 = less, bit 2 = greater, bit 1 = equal, bit 0 = unordered. At most one of bits 3..1 is ever set.
- R3: `rnd_mode` selects the rounding: 0 = nearest-even, 1 = toward zero, 2 = toward +inf, 3 = toward -inf. In nearest-even mode the result rounds up when the guard bit is set and at least one of the round bit, sticky, or the kept LSB is set. In mode 2 the result rounds up only when it is positive and some discarded bit is nonzero; in mode 3, only when it is negative and some discarded bit is nonzero. Mode 1 never rounds up. `out_inx` is set when any discarded bit is nonzero. `out_rnd` is set when an increment actually happened.
- R4: When `in_kind` = 1 (number) and the biased exponent `in_exp`+127 is at least 1, the word is the sign, then the biased exponent, then the rounded 23-bit fraction. A rounding carry that makes the significand 2.0 adds one to the exponent and leaves the fraction zero. The class field holds less when negative and greater when positive.
- R5: A normal result whose biased exponent reaches 255 or more after rounding sets `out_ovf` and `out_inx`. It becomes infinity in mode 0, in mode 2 when positive, and in mode 3 when negative; the class field is then the sign flag plus unordered. In every other case it becomes the largest finite value 0x7F7FFFFF with the sign, and the class field is the sign flag alone.
- R6: When the biased exponent is 0 or less, the significand is shifted right by 1 minus the biased exponent before rounding, and every shifted-out bit joins sticky. A result that stays subnormal has exponent field 0 and class field class bit plus the sign flag.
- R7: A subnormal result that is inexact sets `out_unf`. If its rounded fraction is zero, the word is the sign alone and the class field is equal only (0b00010), whatever the sign.
- R8: A subnormal that rounds up into bit 23 becomes the smallest normal, the sign with exponent field 1 and a zero fraction. Its class field is the sign flag only, and `out_unf` stays clear.
- R9: `in_kind` = 0 (zero) gives the sign alone in bit 31. The class field is equal, plus the class bit when the sign is negative. All four flags are clear.
- R10: `in_kind` = 2 (infinity) gives the sign, exponent 255 and a zero fraction. The class field is the sign flag plus unordered. All four flags are clear.
- R11: `in_kind` = 3 or 4 (quiet or signalling NaN), and the unused codes 5 to 7, give the sign with exponent 255. The fraction is significand bits 24..2 with bit 22 forced to one. The class field is class plus unordered (0b10001). All four flags are clear.
- R12: On each accepted result, `sum_ovf`, `sum_unf` and `sum_inx` are ORed with that result's overflow, underflow and inexact flags. They never clear except by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Accept the current inputs |
| in_kind | input | 3 | Class code: 0 zero, 1 number, 2 infinity, 3 quiet NaN, 4 signalling NaN |
| in_sign | input | 1 | Sign of the result |
| in_exp | input | 10 | Unbiased exponent, two's complement |
| in_mant | input | 26 | Integer bit, 23 fraction bits, guard bit, round bit |
| in_sticky | input | 1 | OR of all lower discarded bits |
| rnd_mode | input | 2 | Rounding mode |
| out_valid | output | 1 | Result loaded in the previous cycle |
| out_word | output | 32 | Packed single-precision word |
| out_cls | output | 5 | Result-class field |
| out_ovf | output | 1 | Overflow for this result |
| out_unf | output | 1 | Underflow for this result |
| out_inx | output | 1 | Inexact for this result |
| out_rnd | output | 1 | Result was rounded up |
| sum_ovf | output | 1 | Accumulated overflow |
| sum_unf | output | 1 | Accumulated underflow |
| sum_inx | output | 1 | Accumulated inexact |

## Verification
Rounding and range handling can act in the same cycle, and they interact in two places. A rounding carry on a significand of all ones at exponent 127 pushes the biased exponent to 255, so the result overflows only because it was rounded. At exponent -127, the same significand first goes through the denormalizing shift and then rounds up into the smallest normal. Directed cases hit both corners under every rounding mode, and random exponents gather around both range edges. A bench model computes each packed word, class field and flag set on its own and compares them with the outputs.

// File: rtl/sp_pack_pkg.sv
package sp_pack_pkg;

  localparam int MANT_W   = 26;          // integer + 23 fraction + guard + round
  localparam int KEEP_W   = MANT_W - 2;  // significand kept after rounding
  localparam int FRAC_W   = KEEP_W - 1;  // stored fraction
  localparam int EXPF_W   = 8;           // exponent field
  localparam int BIAS     = 127;
  localparam int EXP_TOP  = 255;
  localparam int SH_W     = $clog2(MANT_W + 1);

  typedef enum logic [2:0] {
    K_ZERO = 3'd0,
    K_NUM  = 3'd1,
    K_INF  = 3'd2,
    K_QNAN = 3'd3,
    K_SNAN = 3'd4
  } kind_e;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_POS  = 2'd2,
    RM_NEG  = 2'd3
  } rmode_e;

  // class field masks, bit order {class, less, greater, equal, unordered}
  localparam logic [4:0] CF_C  = 5'b10000;
  localparam logic [4:0] CF_LT = 5'b01000;
  localparam logic [4:0] CF_GT = 5'b00100;
  localparam logic [4:0] CF_EQ = 5'b00010;
  localparam logic [4:0] CF_UN = 5'b00001;

  function automatic logic want_increment(rmode_e m, logic sgn, logic lsb,
                                          logic g, logic rs);
    logic any;
    any = g | rs;
    case (m)
      RM_NEAR: return g & (rs | lsb);
      RM_ZERO: return 1'b0;
      RM_POS:  return any & ~sgn;
      default: return any & sgn;
    endcase
  endfunction

  function automatic logic overflow_to_inf(rmode_e m, logic sgn);
    case (m)
      RM_NEAR: return 1'b1;
      RM_ZERO: return 1'b0;
      RM_POS:  return ~sgn;
      default: return sgn;
    endcase
  endfunction

  function automatic logic [4:0] sign_flag(logic sgn);
    return sgn ? CF_LT : CF_GT;
  endfunction

endpackage

// File: rtl/sp_align_shift.sv
module sp_align_shift
  import sp_pack_pkg::*;
#(
  parameter int MW = MANT_W,
  parameter int SW = SH_W
) (
  input  logic [MW-1:0] mant_i,
  input  logic          sticky_i,
  input  logic [SW-1:0] sh_i,
  output logic [MW-1:0] mant_o,
  output logic          sticky_o
);
  localparam int WW = 2 * MW;

  logic [WW-1:0] wide;

  assign wide     = {mant_i, {MW{1'b0}}} >> sh_i;
  assign mant_o   = wide[WW-1:MW];
  assign sticky_o = sticky_i | (|wide[MW-1:0]);

endmodule

// File: rtl/sp_round_unit.sv
module sp_round_unit
  import sp_pack_pkg::*;
#(
  parameter int KW = KEEP_W
) (
  input  logic [KW-1:0] keep_i,
  input  logic          g_i,
  input  logic          rs_i,
  input  logic          sgn_i,
  input  rmode_e        mode_i,
  output logic [KW:0]   sum_o,
  output logic          inexact_o,
  output logic          incr_o
);
  assign inexact_o = g_i | rs_i;
  assign incr_o    = want_increment(mode_i, sgn_i, keep_i[0], g_i, rs_i);
  assign sum_o     = {1'b0, keep_i} + {{KW{1'b0}}, incr_o};

endmodule

// File: rtl/sp_result_encode.sv
module sp_result_encode
  import sp_pack_pkg::*;
#(
  parameter int BW = 12,
  parameter int KW = KEEP_W,
  parameter int FW = FRAC_W
) (
  input  kind_e                kind_i,
  input  logic                 sgn_i,
  input  logic                 sub_i,
  input  logic signed [BW-1:0] be_i,
  input  logic [KW:0]          sum_i,
  input  logic                 inexact_i,
  input  logic                 incr_i,
  input  logic [FW-1:0]        nan_frac_i,
  input  rmode_e               mode_i,
  output logic [31:0]          word_o,
  output logic [4:0]           cls_o,
  output logic                 ovf_o,
  output logic                 unf_o,
  output logic                 inx_o,
  output logic                 rnd_o,
  output logic                 ev_promote_o,
  output logic                 ev_ovf_o
);
  localparam logic signed [BW-1:0] TOP_S = BW'(EXP_TOP);
  localparam logic [FW-1:0]        QBIT  = FW'(1) << (FW - 1);

  logic signed [BW-1:0] be_fin;
  logic [4:0]           sf;
  logic                 carry;

  assign carry        = sum_i[KW];
  assign be_fin       = be_i + $signed({{(BW-1){1'b0}}, carry});
  assign sf           = sign_flag(sgn_i);
  assign ev_promote_o = (kind_i == K_NUM) && sub_i && sum_i[KW-1];
  assign ev_ovf_o     = (kind_i == K_NUM) && !sub_i && (be_fin >= TOP_S);

  always_comb begin
    word_o = 32'd0;
    cls_o  = 5'd0;
    ovf_o  = 1'b0;
    unf_o  = 1'b0;
    inx_o  = 1'b0;
    rnd_o  = 1'b0;
    case (kind_i)
      K_ZERO: begin
        word_o = {sgn_i, 31'd0};
        cls_o  = CF_EQ | (sgn_i ? CF_C : 5'd0);
      end
      K_INF: begin
        word_o = {sgn_i, 8'hFF, 23'd0};
        cls_o  = sf | CF_UN;
      end
      K_NUM: begin
        inx_o = inexact_i;
        rnd_o = incr_i;
        if (sub_i) begin
          if (ev_promote_o) begin
            word_o = {sgn_i, 8'd1, 23'd0};
            cls_o  = sf;
          end else if (inexact_i && (sum_i[FW-1:0] == '0)) begin
            unf_o  = 1'b1;
            word_o = {sgn_i, 31'd0};
            cls_o  = CF_EQ;
          end else begin
            unf_o  = inexact_i;
            word_o = {sgn_i, 8'd0, sum_i[FW-1:0]};
            cls_o  = CF_C | sf;
          end
        end else if (ev_ovf_o) begin
          ovf_o = 1'b1;
          inx_o = 1'b1;
          if (overflow_to_inf(mode_i, sgn_i)) begin
            word_o = {sgn_i, 8'hFF, 23'd0};
            cls_o  = sf | CF_UN;
          end else begin
            word_o = {sgn_i, 31'h7F7FFFFF};
            cls_o  = sf;
          end
        end else begin
          word_o = {sgn_i, be_fin[EXPF_W-1:0], (carry ? '0 : sum_i[FW-1:0])};
          cls_o  = sf;
        end
      end
      default: begin
        word_o = {sgn_i, 8'hFF, nan_frac_i | QBIT};
        cls_o  = CF_C | CF_UN;
      end
    endcase
  end

endmodule

// File: rtl/sp_result_packer.sv
module sp_result_packer
  import sp_pack_pkg::*;
#(
  parameter int EXP_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        in_kind,
  input  logic              in_sign,
  input  logic [EXP_W-1:0]  in_exp,
  input  logic [MANT_W-1:0] in_mant,
  input  logic              in_sticky,
  input  logic [1:0]        rnd_mode,
  output logic              out_valid,
  output logic [31:0]       out_word,
  output logic [4:0]        out_cls,
  output logic              out_ovf,
  output logic              out_unf,
  output logic              out_inx,
  output logic              out_rnd,
  output logic              sum_ovf,
  output logic              sum_unf,
  output logic              sum_inx
);
  localparam int BW = EXP_W + 2;
  localparam logic signed [BW-1:0] BIAS_S = BW'(BIAS);
  localparam logic signed [BW-1:0] ONE_S  = BW'(1);
  localparam logic signed [BW-1:0] CAP_S  = BW'(MANT_W);

  kind_e                kind;
  rmode_e               mode;
  logic signed [BW-1:0] biased;
  logic signed [BW-1:0] need_sh;
  logic                 is_sub;
  logic [SH_W-1:0]      sh;
  logic [MANT_W-1:0]    mant_al;
  logic                 sticky_al;
  logic [KEEP_W:0]      rsum;
  logic                 r_inexact;
  logic                 r_incr;
  logic [31:0]          e_word;
  logic [4:0]           e_cls;
  logic                 e_ovf, e_unf, e_inx, e_rnd;
  // named internal events for the checks below
  logic                 ev_promote;
  logic                 ev_ovf;
  logic                 ev_norm_carry;

  assign kind    = kind_e'(in_kind);
  assign mode    = rmode_e'(rnd_mode);
  assign biased  = BW'($signed(in_exp)) + BIAS_S;
  assign is_sub  = (biased <= 0);
  assign need_sh = ONE_S - biased;

  always_comb begin
    if (!is_sub)               sh = '0;
    else if (need_sh > CAP_S)  sh = SH_W'(MANT_W);
    else                       sh = need_sh[SH_W-1:0];
  end

  sp_align_shift #(.MW(MANT_W), .SW(SH_W)) u_align (
    .mant_i   (in_mant),
    .sticky_i (in_sticky),
    .sh_i     (sh),
    .mant_o   (mant_al),
    .sticky_o (sticky_al)
  );

  sp_round_unit #(.KW(KEEP_W)) u_round (
    .keep_i    (mant_al[MANT_W-1:2]),
    .g_i       (mant_al[1]),
    .rs_i      (mant_al[0] | sticky_al),
    .sgn_i     (in_sign),
    .mode_i    (mode),
    .sum_o     (rsum),
    .inexact_o (r_inexact),
    .incr_o    (r_incr)
  );

  sp_result_encode #(.BW(BW), .KW(KEEP_W), .FW(FRAC_W)) u_encode (
    .kind_i       (kind),
    .sgn_i        (in_sign),
    .sub_i        (is_sub),
    .be_i         (biased),
    .sum_i        (rsum),
    .inexact_i    (r_inexact),
    .incr_i       (r_incr),
    .nan_frac_i   (in_mant[MANT_W-2:2]),
    .mode_i       (mode),
    .word_o       (e_word),
    .cls_o        (e_cls),
    .ovf_o        (e_ovf),
    .unf_o        (e_unf),
    .inx_o        (e_inx),
    .rnd_o        (e_rnd),
    .ev_promote_o (ev_promote),
    .ev_ovf_o     (ev_ovf)
  );

  assign ev_norm_carry = (kind == K_NUM) && !is_sub && rsum[KEEP_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_cls   <= '0;
      out_ovf   <= 1'b0;
      out_unf   <= 1'b0;
      out_inx   <= 1'b0;
      out_rnd   <= 1'b0;
      sum_ovf   <= 1'b0;
      sum_unf   <= 1'b0;
      sum_inx   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word <= e_word;
        out_cls  <= e_cls;
        out_ovf  <= e_ovf;
        out_unf  <= e_unf;
        out_inx  <= e_inx;
        out_rnd  <= e_rnd;
        sum_ovf  <= sum_ovf | e_ovf;
        sum_unf  <= sum_unf | e_unf;
        sum_inx  <= sum_inx | e_inx;
      end
    end
  end

  // R2
  cls_sign_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0(out_cls[3:1]));

  // R3
  rounded_needs_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_rnd |-> out_inx);

  // R4
  carry_zero_frac_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && ev_norm_carry && !ev_ovf |=> out_word[22:0] == 23'd0);

  // R5
  overflow_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && ev_ovf |=> out_ovf && out_inx && out_word[30:23] >= 8'hFE);

  // R7
  underflow_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_unf |-> out_inx && !out_ovf);

  // R8
  promote_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && ev_promote |=> !out_unf && out_word[30:0] == 31'h00800000);

  // R12
  sum_inx_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sum_inx |=> sum_inx);

  // R12
  sum_ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sum_ovf |=> sum_ovf);

endmodule

// File: tb/test_sp_result_packer.sv
`timescale 1ns/1ps
module test_sp_result_packer;

  typedef struct packed {
    logic [31:0] word;
    logic [4:0]  cls;
    logic        ovf;
    logic        unf;
    logic        inx;
    logic        rnd;
  } res_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  in_kind = 3'd0;
  logic        in_sign = 1'b0;
  logic [9:0]  in_exp = 10'd0;
  logic [25:0] in_mant = 26'd0;
  logic        in_sticky = 1'b0;
  logic [1:0]  rnd_mode = 2'd0;
  logic        out_valid;
  logic [31:0] out_word;
  logic [4:0]  out_cls;
  logic        out_ovf, out_unf, out_inx, out_rnd;
  logic        sum_ovf, sum_unf, sum_inx;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;
  bit x_ovf = 0, x_unf = 0, x_inx = 0;

  always #2 clk = ~clk;

  sp_result_packer i_sp_result_packer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
    .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant),
    .in_sticky(in_sticky), .rnd_mode(rnd_mode), .out_valid(out_valid),
    .out_word(out_word), .out_cls(out_cls), .out_ovf(out_ovf),
    .out_unf(out_unf), .out_inx(out_inx), .out_rnd(out_rnd),
    .sum_ovf(sum_ovf), .sum_unf(sum_unf), .sum_inx(sum_inx)
  );

  // independent model built from the requirements
  function automatic res_t model(int kind, bit sg, int e, bit [25:0] m,
                                 bit st, int md);
    res_t r;
    bit [4:0] sf;
    int be, sh, bf;
    bit [63:0] w;
    bit [23:0] kept;
    bit g, rs, up, inexact, to_inf;
    bit [24:0] s;
    r = '0;
    sf = sg ? 5'b01000 : 5'b00100;
    if (kind == 0) begin
      r.word = {sg, 31'd0};
      r.cls = sg ? 5'b10010 : 5'b00010;
    end else if (kind == 2) begin
      r.word = {sg, 8'hFF, 23'd0};
      r.cls = sf | 5'b00001;
    end else if (kind != 1) begin
      r.word = {sg, 8'hFF, m[24:2] | 23'h400000};
      r.cls = 5'b10001;
    end else begin
      be = e + 127;
      sh = (be <= 0) ? 1 - be : 0;
      if (sh > 40) sh = 40;
      w = {m, 38'd0} >> sh;
      kept = w[63:40];
      g = w[39];
      rs = (|w[38:0]) | st;
      inexact = g | rs;
      case (md)
        0: up = g && (rs || kept[0]);
        1: up = 0;
        2: up = inexact && !sg;
        default: up = inexact && sg;
      endcase
      s = {1'b0, kept} + 25'(up);
      r.inx = inexact;
      r.rnd = up;
      if (be <= 0) begin
        if (s[23]) begin
          r.word = {sg, 8'd1, 23'd0};
          r.cls = sf;
        end else if (inexact && s[22:0] == 0) begin
          r.unf = 1;
          r.word = {sg, 31'd0};
          r.cls = 5'b00010;
        end else begin
          r.unf = inexact;
          r.word = {sg, 8'd0, s[22:0]};
          r.cls = 5'b10000 | sf;
        end
      end else begin
        bf = be + int'(s[24]);
        if (bf >= 255) begin
          r.ovf = 1;
          r.inx = 1;
          to_inf = (md == 0) || (md == 2 && !sg) || (md == 3 && sg);
          r.word = to_inf ? {sg, 8'hFF, 23'd0} : {sg, 31'h7F7FFFFF};
          r.cls = to_inf ? (sf | 5'b00001) : sf;
        end else begin
          r.word = {sg, bf[7:0], s[24] ? 23'd0 : s[22:0]};
          r.cls = sf;
        end
      end
    end
    return r;
  endfunction

  function automatic string req_of(int kind, int e, res_t r);
    if (kind == 0) return "R9";
    if (kind == 2) return "R10";
    if (kind != 1) return "R11";
    if (r.ovf) return "R5";
    if (e + 127 <= 0) begin
      if (r.word[30:23] == 8'd1) return "R8";
      if (r.unf) return "R7";
      return "R6";
    end
    if (r.rnd) return "R3";
    return "R4";
  endfunction

  task automatic check_res(string req, res_t exp_r);
    res_t act;
    act = {out_word, out_cls, out_ovf, out_unf, out_inx, out_rnd};
    checks++;
    if (act !== exp_r || out_valid !== 1'b1) begin
      failures++;
      $display("FAIL %s: actual word=%h cls=%b o/u/x/r=%b%b%b%b v=%b expected word=%h cls=%b o/u/x/r=%b%b%b%b v=1",
               req, act.word, act.cls, act.ovf, act.unf, act.inx, act.rnd, out_valid,
               exp_r.word, exp_r.cls, exp_r.ovf, exp_r.unf, exp_r.inx, exp_r.rnd);
    end
  endtask

  task automatic check_sums();
    checks++;
    if ({sum_ovf, sum_unf, sum_inx} !== {x_ovf, x_unf, x_inx}) begin
      failures++;
      $display("FAIL R12: actual sums=%b%b%b expected=%b%b%b",
               sum_ovf, sum_unf, sum_inx, x_ovf, x_unf, x_inx);
    end
  endtask

  task automatic run_op(int kind, bit sg, int e, bit [25:0] m, bit st, int md,
                        bit with_sum_check);
    res_t r;
    r = model(kind, sg, e, m, st, md);
    @(negedge clk);
    in_kind = 3'(kind); in_sign = sg; in_exp = 10'(e);
    in_mant = m; in_sticky = st; rnd_mode = 2'(md); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    x_ovf |= r.ovf; x_unf |= r.unf; x_inx |= r.inx;
    check_res(req_of(kind, e, r), r);
    if (with_sum_check) check_sums();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog: actual cycles=%0d expected below 150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    res_t held;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if ({out_valid, out_word, out_cls, out_ovf, out_unf, out_inx, out_rnd,
         sum_ovf, sum_unf, sum_inx} !== '0) begin
      failures++;
      $display("FAIL R1: actual word=%h cls=%b expected all zero", out_word, out_cls);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if ({out_valid, out_word, out_cls, sum_inx} !== '0) begin
      failures++;
      $display("FAIL R1: actual word=%h valid=%b expected zero after release", out_word, out_valid);
    end

    // R4 plain 1.0 and 2.0 carry
    run_op(1, 0, 0, 26'h2000000, 0, 0, 1);
    run_op(1, 0, 0, 26'h3FFFFFF, 0, 0, 1);
    // R3 ties and directed modes
    run_op(1, 0, 0, {1'b1, 23'h000001, 2'b10}, 0, 0, 1);
    run_op(1, 0, 0, {1'b1, 23'h000002, 2'b10}, 0, 0, 1);
    run_op(1, 1, 3, {1'b1, 23'h123456, 2'b01}, 0, 2, 1);
    run_op(1, 1, 3, {1'b1, 23'h123456, 2'b00}, 1, 3, 1);
    run_op(1, 0, 5, {1'b1, 23'h7ABCDE, 2'b11}, 1, 1, 1);
    // R5 overflow under each mode, and carry-driven overflow
    for (int md = 0; md < 4; md++) begin
      run_op(1, 0, 128, 26'h2000000, 0, md, 1);
      run_op(1, 1, 127, 26'h3FFFFFF, 0, md, 1);
    end
    // R6 exact subnormal, R7 flush, R8 promotion
    run_op(1, 0, -127, 26'h2000000, 0, 0, 1);
    run_op(1, 1, -130, 26'h2C00000, 0, 1, 1);
    run_op(1, 1, -200, 26'h2000000, 0, 1, 1);
    run_op(1, 0, -200, 26'h2000000, 0, 2, 1);
    for (int md = 0; md < 4; md++) run_op(1, md[0], -127, 26'h3FFFFFF, 0, md, 1);
    // R9 R10 R11 specials
    run_op(0, 0, 0, 26'd0, 0, 0, 1);
    run_op(0, 1, 0, 26'd0, 0, 0, 1);
    run_op(2, 1, 0, 26'd0, 0, 0, 1);
    run_op(2, 0, 0, 26'd0, 0, 3, 1);
    run_op(3, 1, 0, 26'h2A5A5A4, 0, 0, 1);
    run_op(4, 0, 0, 26'h2000004, 0, 0, 1);

    // R2 inputs ignored without in_valid
    held = {out_word, out_cls, out_ovf, out_unf, out_inx, out_rnd};
    @(negedge clk);
    in_kind = 3'd1; in_exp = 10'd140; in_mant = 26'h3FFFFFF; in_sticky = 1'b1;
    in_sign = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if ({out_word, out_cls, out_ovf, out_unf, out_inx, out_rnd} !== held || out_valid !== 1'b0) begin
      failures++;
      $display("FAIL R2: actual word=%h valid=%b expected word=%h valid=0", out_word, out_valid, held.word);
    end
    check_sums();

    // random mix clustered at the range edges
    for (int i = 0; i < 3000; i++) begin
      int kind, e, sel;
      bit [25:0] m;
      sel = int'($urandom_range(0, 19));
      kind = (sel < 16) ? 1 : int'($urandom_range(0, 4));
      case ($urandom_range(0, 3))
        0: e = int'($urandom_range(0, 20)) + 118;
        1: e = -int'($urandom_range(120, 155));
        2: e = int'($urandom_range(0, 300)) - 160;
        default: e = int'($urandom_range(0, 60)) - 30;
      endcase
      m = {1'b1, 25'($urandom)};
      if ($urandom_range(0, 7) == 0) m = 26'h3FFFFFF;
      run_op(kind, 1'($urandom), e, m, 1'($urandom), int'($urandom_range(0, 3)), (i % 50) == 0);
    end

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule